// File: doc/BRIEF.md
# SDRAM Self-Refresh Power Manager

This block decides when an SDRAM controller parks the memory in self-refresh and when it brings it back. It watches two strobes from the controller: one for an access issued and one for an auto-refresh issued. Between them it counts idle cycles. Once the count reaches a programmable threshold, and automatic entry is enabled, it issues the self-refresh command and holds CKE low. In self-refresh, the SDRAM clock can optionally be stopped to save power.

A held access request, or clearing the enable, wakes the memory through a fixed sequence. The sequence restarts the clock, raises CKE, issues a precharge-all and waits out tRP. If an access request caused the wake-up, the block then releases it with a one-cycle grant. The controller's normal read/write sequencing and its periodic auto-refresh timer live outside this block. A request is assumed to stay high until it is granted.

Top module: `sdram_selfref_mgr`

## Requirements
- R1: After reset the block drives cke=1, cmd=NOP (4'b0111), cmd_a10=0, sdclk_en=1, sref_n_status=1 and acc_grant=0.
- R2: Let a strobe be sampled at clock edge E, with no later strobe and no request. Entry is decided at edge E+T+1, where T is the effective threshold. In the cycle after that edge, cmd carries SELF (4'b0001, bits are {cs_n,ras_n,cas_n,we_n}) with cke=0. From the next cycle on, cmd is NOP and cke stays 0.
- R3: Either access_strobe or aref_strobe restarts the idle count from zero. No entry is decided at an edge where either strobe is high.
- R4: While sref_en is 0, self-refresh is never entered, however long the block stays idle.
- R5: A threshold of 0 or 1 behaves as 2. Thresholds from 2 to 15 are used as given.
- R6: sref_n_status is 0 exactly while cke is low and 1 otherwise.
- R7: sdclk_en is 1 in the entry cycle and in every cycle outside self-refresh. In the steady self-refresh state it follows clk_out_en.
- R8: Suppose acc_req is sampled high in self-refresh at edge X. Then, in the cycles after X:
  - after X, the clock runs with cke still 0;
  - after X+1, cke=1 and cmd=NOP;
  - after X+2, cmd=PALL (4'b0010) with cmd_a10=1;
  - after X+3 through X+2+TRP_CYC, cmd=NOP;
  - after X+3+TRP_CYC, acc_grant is 1 for exactly one cycle.
- R9: Clearing sref_en during self-refresh runs the same exit sequence as R8, but without a grant.
- R10: No entry is decided at an edge where acc_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sref_en | input | 1 | Enables automatic self-refresh entry |
| idle_limit | input | 4 | Idle threshold in cycles (0 and 1 act as 2) |
| clk_out_en | input | 1 | Keep the SDRAM clock running in self-refresh when 1 |
| access_strobe | input | 1 | Controller issued an SDRAM access this cycle |
| aref_strobe | input | 1 | Controller issued an auto-refresh this cycle |
| acc_req | input | 1 | Pending access request, held until granted |
| cke | output | 1 | SDRAM clock enable pin |
| cmd | output | 4 | Command lines {cs_n,ras_n,cas_n,we_n} |
| cmd_a10 | output | 1 | Address bit 10, high for precharge-all |
| sdclk_en | output | 1 | Enable for the SDRAM clock output |
| sref_n_status | output | 1 | 0 while in self-refresh |
| acc_grant | output | 1 | One-cycle release of the pending access |

## Verification
The assertions check several rules on every cycle:
- CKE falls only with SELF on the bus and with the clock running.
- Entry is decided only with the enable set, with no strobe and with no request.
- CKE rises only after a cycle with the clock running.
- A stopped clock implies self-refresh with clk_out_en low.
- Status tracks CKE.
- The grant lasts one cycle and only with CKE high.

Only the bench scenarios can show the exact idle count before entry and the threshold clamp. The same holds for the restart by either strobe and for the full exit timeline through tRP. Whether a grant appears or not, depending on what caused the exit, is also shown only by the scenarios.

// File: rtl/sref_pkg.sv
// Shared types for the self-refresh manager.
// Assumes commands are encoded as {cs_n, ras_n, cas_n, we_n}.
package sref_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_SELF = 4'b0001,
        CMD_PALL = 4'b0010
    } sd_cmd_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ENTER,
        ST_SLEEP,
        ST_WAKE_CLK,
        ST_WAKE_CKE,
        ST_PALL,
        ST_TRP,
        ST_GRANT
    } sref_state_t;

endpackage

// File: rtl/sref_idle_cnt.sv
// Idle counter: advances once per clock and saturates at its maximum.
// It returns to zero when restart is high. The reached output compares
// the count with the programmed limit, after raising that limit to MIN_LIM.
// Assumes restart covers every activity that must postpone entry.
module sref_idle_cnt #(
    parameter int CNT_W   = 4,
    parameter int MIN_LIM = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM_MIN = CNT_W'(MIN_LIM);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_eff;

    // Count idle cycles, restart on activity, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (restart)     cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Clamp the threshold so that a too-small setting cannot lock the memory in.
    always_comb begin
        lim_eff = (limit < LIM_MIN) ? LIM_MIN : limit;
        reached = (cnt >= lim_eff);
    end

    // R3: a restart leaves the count at zero on the next cycle.
    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R5: the threshold can never be met straight after a restart.
    assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !reached);
endmodule

// File: rtl/sref_trp_timer.sv
// Precharge wait timer: load sets the remaining count to TRP_CYC.
// Each cycle with run high counts it down, and last flags the final cycle.
// Assumes TRP_CYC >= 1 and that run starts in the cycle after load.
module sref_trp_timer #(
    parameter int TRP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int TW = $clog2(TRP_CYC + 1);
    localparam logic [TW-1:0] TRP_LD = TW'(TRP_CYC);

    logic [TW-1:0] rem;

    // Load the wait length at precharge, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rem <= '0;
        else if (load)              rem <= TRP_LD;
        else if (run && rem != '0)  rem <= rem - 1'b1;
    end

    // Flag the last waiting cycle.
    always_comb last = run && (rem == TW'(1));

    // R8: the wait never runs past its end.
    assert_no_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (rem != '0));
endmodule

// File: rtl/sref_seq.sv
// Self-refresh sequencer. It enters self-refresh when idle and enabled.
// It leaves on a request or when the enable is cleared:
// clock on, CKE up, precharge-all, tRP wait, grant.
// Assumes a request is held until granted.
module sref_seq (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sref_en,
    input  logic                 clk_out_en,
    input  logic                 activity,
    input  logic                 acc_req,
    input  logic                 idle_reached,
    input  logic                 trp_last,
    output sref_pkg::sref_state_t state,
    output logic                 cke,
    output sref_pkg::sd_cmd_t    cmd,
    output logic                 cmd_a10,
    output logic                 sdclk_en,
    output logic                 acc_grant
);
    import sref_pkg::*;

    sref_state_t nxt;
    logic        by_req;
    logic        go_sleep;
    logic        wake;

    // Entry and exit conditions.
    always_comb begin
        go_sleep = sref_en && idle_reached && !activity && !acc_req;
        wake     = acc_req || !sref_en;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (go_sleep) nxt = ST_ENTER;
            ST_ENTER:    nxt = ST_SLEEP;
            ST_SLEEP:    if (wake) nxt = ST_WAKE_CLK;
            ST_WAKE_CLK: nxt = ST_WAKE_CKE;
            ST_WAKE_CKE: nxt = ST_PALL;
            ST_PALL:     nxt = ST_TRP;
            ST_TRP:      if (trp_last) nxt = ST_GRANT;
            ST_GRANT:    nxt = ST_RUN;
            default:     nxt = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Remember whether a request caused the wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n)                          by_req <= 1'b0;
        else if (state == ST_SLEEP && wake)  by_req <= acc_req;
        else if (state == ST_GRANT)          by_req <= 1'b0;
    end

    // Pin and command outputs decoded from the state.
    always_comb begin
        cke       = !(state == ST_ENTER || state == ST_SLEEP || state == ST_WAKE_CLK);
        cmd       = (state == ST_ENTER) ? CMD_SELF :
                    (state == ST_PALL)  ? CMD_PALL : CMD_NOP;
        cmd_a10   = (state == ST_PALL);
        sdclk_en  = (state == ST_SLEEP) ? clk_out_en : 1'b1;
        acc_grant = (state == ST_GRANT) && by_req;
    end

    // R9: a grant follows only a request-driven exit.
    assert_grant_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !acc_req && !sref_en) |=> !by_req);

    // R8: precharge is always followed by the tRP wait.
    assert_pall_then_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PALL) |=> (state == ST_TRP));
endmodule

// File: rtl/sdram_selfref_mgr.sv
// Top of the SDRAM self-refresh manager. It combines the idle counter,
// the tRP timer and the sequencer.
// Assumes the strobes pulse for one cycle per command issued.
module sdram_selfref_mgr #(
    parameter int LIM_W   = 4,
    parameter int MIN_LIM = 2,
    parameter int TRP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sref_en,
    input  logic [LIM_W-1:0] idle_limit,
    input  logic             clk_out_en,
    input  logic             access_strobe,
    input  logic             aref_strobe,
    input  logic             acc_req,
    output logic             cke,
    output logic [3:0]       cmd,
    output logic             cmd_a10,
    output logic             sdclk_en,
    output logic             sref_n_status,
    output logic             acc_grant
);
    import sref_pkg::*;

    sref_state_t state;
    sd_cmd_t     cmd_e;
    logic        activity;
    logic        idle_reached;
    logic        trp_last;

    // Activity merge and the counter restart: any command, or leaving normal run.
    always_comb activity = access_strobe || aref_strobe;

    sref_idle_cnt #(.CNT_W(LIM_W), .MIN_LIM(MIN_LIM)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (activity || state != ST_RUN),
        .limit   (idle_limit),
        .reached (idle_reached)
    );

    sref_trp_timer #(.TRP_CYC(TRP_CYC)) u_trp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_PALL),
        .run   (state == ST_TRP),
        .last  (trp_last)
    );

    sref_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sref_en      (sref_en),
        .clk_out_en   (clk_out_en),
        .activity     (activity),
        .acc_req      (acc_req),
        .idle_reached (idle_reached),
        .trp_last     (trp_last),
        .state        (state),
        .cke          (cke),
        .cmd          (cmd_e),
        .cmd_a10      (cmd_a10),
        .sdclk_en     (sdclk_en),
        .acc_grant    (acc_grant)
    );

    // Port-level outputs.
    always_comb begin
        cmd           = cmd_e;
        sref_n_status = cke;
    end

    // R4: CKE falls only after an enabled decision.
    assert_entry_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(sref_en));
    // R3: no entry decision in a cycle with a strobe.
    assert_entry_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(!access_strobe && !aref_strobe));
    // R10: no entry decision while a request is pending.
    assert_entry_noreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(acc_req));
    // R2: CKE falls together with the SELF command.
    assert_entry_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd == CMD_SELF));
    // R7: CKE is lowered with the clock running.
    assert_fall_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> sdclk_en);
    // R8: CKE rises only after a cycle with the clock running.
    assert_rise_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> $past(sdclk_en));
    // R7: the clock stops only in self-refresh with the stop option chosen.
    assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sdclk_en |-> (!cke && !clk_out_en));
    // R6: status follows CKE.
    assert_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sref_n_status == cke);
    // R8: the grant is a single pulse, given with CKE high.
    assert_grant_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |=> !acc_grant);
    assert_grant_cke_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> cke);
endmodule

// File: tb/sim_sdram_selfref_mgr.sv
// Scoreboard bench: driver tasks queue expected (cycle, signal, value) items.
// A negedge monitor pops and compares them.
module sim_sdram_selfref_mgr;
    localparam int TRP = 3;
    localparam int NOP = 7, SELF = 1, PALL = 2;
    localparam int S_CKE = 0, S_CMD = 1, S_A10 = 2, S_CLK = 3, S_STAT = 4, S_GNT = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sref_en = 1'b0, clk_out_en = 1'b1, access_strobe = 1'b0, aref_strobe = 1'b0, acc_req = 1'b0;
    logic [3:0] idle_limit = 4'd4;
    logic cke, cmd_a10, sdclk_en, sref_n_status, acc_grant;
    logic [3:0] cmd;

    int cyc = 0, total = 0, bad = 0;

    typedef struct { int c; int sig; int val; string tag; } exp_t;
    exp_t q[$];

    sdram_selfref_mgr #(.LIM_W(4), .MIN_LIM(2), .TRP_CYC(TRP)) u0 (
        .clk(clk), .rst_n(rst_n), .sref_en(sref_en), .idle_limit(idle_limit),
        .clk_out_en(clk_out_en), .access_strobe(access_strobe), .aref_strobe(aref_strobe),
        .acc_req(acc_req), .cke(cke), .cmd(cmd), .cmd_a10(cmd_a10), .sdclk_en(sdclk_en),
        .sref_n_status(sref_n_status), .acc_grant(acc_grant));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sample(int s);
        case (s)
            S_CKE:  return int'(cke);
            S_CMD:  return int'(cmd);
            S_A10:  return int'(cmd_a10);
            S_CLK:  return int'(sdclk_en);
            S_STAT: return int'(sref_n_status);
            default: return int'(acc_grant);
        endcase
    endfunction

    // Queue an item in cycle order.
    task automatic expect_at(int c, int sig, int val, string tag);
        exp_t e;
        int i;
        e.c = c; e.sig = sig; e.val = val; e.tag = tag;
        i = 0;
        while (i < q.size() && q[i].c <= c) i++;
        q.insert(i, e);
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].c <= cyc) begin
            exp_t e;
            int a;
            e = q.pop_front();
            a = sample(e.sig);
            total++;
            if (e.c < cyc || a != e.val) begin
                bad++;
                $display("FAIL %s cyc=%0d sig=%0d actual=%0d expected=%0d", e.tag, e.c, e.sig, a, e.val);
            end
        end
    end

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Pulse one strobe for one cycle; returns the cycle it was driven in.
    task automatic pulse(bit aref, output int c);
        if (aref) aref_strobe = 1'b1; else access_strobe = 1'b1;
        c = cyc;
        @(negedge clk);
        aref_strobe = 1'b0; access_strobe = 1'b0;
    endtask

    // Expected exit timeline for a wake sampled at the edge after cycle x.
    task automatic exp_exit(int x, int gnt, string tag);
        expect_at(x + 1, S_CKE, 0, tag);
        expect_at(x + 1, S_CLK, 1, tag);
        expect_at(x + 2, S_CKE, 1, tag);
        expect_at(x + 2, S_STAT, 1, "R6");
        expect_at(x + 2, S_CMD, NOP, tag);
        expect_at(x + 3, S_CMD, PALL, tag);
        expect_at(x + 3, S_A10, 1, tag);
        expect_at(x + 4, S_CMD, NOP, tag);
        expect_at(x + 3 + TRP, S_GNT, 0, tag);
        expect_at(x + 4 + TRP, S_GNT, gnt, tag);
        expect_at(x + 5 + TRP, S_GNT, 0, tag);
    endtask

    // Quiet the block before a new scenario.
    task automatic idle_off();
        sref_en = 1'b0; acc_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : wdog
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : drive
        int c, x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_at(cyc + 1, S_CKE, 1, "R1");
        expect_at(cyc + 1, S_CMD, NOP, "R1");
        expect_at(cyc + 1, S_A10, 0, "R1");
        expect_at(cyc + 1, S_CLK, 1, "R1");
        expect_at(cyc + 1, S_STAT, 1, "R1");
        expect_at(cyc + 1, S_GNT, 0, "R1");
        repeat (2) @(negedge clk);

        // R2/R7/R8: threshold 4, clock stopped in sleep, request exit
        idle_off();
        idle_limit = 4'd4; clk_out_en = 1'b0; sref_en = 1'b1;
        access_strobe = 1'b1;
        c = cyc;
        expect_at(c + 5, S_CKE, 1, "R2");
        expect_at(c + 6, S_CKE, 0, "R2");
        expect_at(c + 6, S_CMD, SELF, "R2");
        expect_at(c + 6, S_CLK, 1, "R7");
        expect_at(c + 6, S_STAT, 0, "R6");
        expect_at(c + 7, S_CMD, NOP, "R2");
        expect_at(c + 7, S_CLK, 0, "R7");
        expect_at(c + 9, S_CKE, 0, "R2");
        @(negedge clk);
        access_strobe = 1'b0;
        wait_until(c + 10);
        acc_req = 1'b1;
        x = cyc;
        exp_exit(x, 1, "R8");
        wait_until(x + 5 + TRP);
        acc_req = 1'b0;

        // R3/R9: restart by aref strobe, then exit by clearing enable
        idle_off();
        idle_limit = 4'd5; clk_out_en = 1'b1; sref_en = 1'b1;
        pulse(1'b0, c);
        wait_until(c + 3);
        pulse(1'b1, c);
        expect_at(c + 1, S_CKE, 1, "R3");
        expect_at(c + 6, S_CKE, 1, "R3");
        expect_at(c + 7, S_CKE, 0, "R3");
        expect_at(c + 8, S_CLK, 1, "R7");
        wait_until(c + 10);
        sref_en = 1'b0;
        x = cyc;
        exp_exit(x, 0, "R9");
        wait_until(x + 6 + TRP);

        // R4: disabled, long idle
        idle_off();
        idle_limit = 4'd2;
        pulse(1'b0, c);
        expect_at(c + 20, S_CKE, 1, "R4");
        expect_at(c + 40, S_CKE, 1, "R4");
        expect_at(c + 40, S_STAT, 1, "R4");
        wait_until(c + 41);

        // R5: threshold 0 acts as 2
        idle_off();
        idle_limit = 4'd0; clk_out_en = 1'b1; sref_en = 1'b1;
        access_strobe = 1'b1;
        c = cyc;
        expect_at(c + 3, S_CKE, 1, "R5");
        expect_at(c + 4, S_CKE, 0, "R5");
        @(negedge clk);
        access_strobe = 1'b0;
        wait_until(c + 8);
        acc_req = 1'b1;
        x = cyc;
        exp_exit(x, 1, "R8");
        wait_until(x + 5 + TRP);
        acc_req = 1'b0;

        // R5: threshold 1 acts as 2
        idle_off();
        idle_limit = 4'd1; sref_en = 1'b1;
        access_strobe = 1'b1;
        c = cyc;
        expect_at(c + 3, S_CKE, 1, "R5");
        expect_at(c + 4, S_CKE, 0, "R5");
        @(negedge clk);
        access_strobe = 1'b0;
        wait_until(c + 8);
        sref_en = 1'b0;
        wait_until(c + 16);

        // R2: maximum threshold 15
        idle_off();
        idle_limit = 4'd15; sref_en = 1'b1;
        access_strobe = 1'b1;
        c = cyc;
        expect_at(c + 16, S_CKE, 1, "R2");
        expect_at(c + 17, S_CKE, 0, "R2");
        @(negedge clk);
        access_strobe = 1'b0;
        wait_until(c + 19);
        sref_en = 1'b0;
        wait_until(c + 28);

        // R10: a held request blocks entry
        idle_off();
        idle_limit = 4'd3; acc_req = 1'b1;
        pulse(1'b0, c);
        sref_en = 1'b1;
        expect_at(c + 20, S_CKE, 1, "R10");
        expect_at(c + 20, S_GNT, 0, "R10");
        wait_until(c + 21);
        acc_req = 1'b0;
        expect_at(cyc + 5, S_CKE, 0, "R10");
        wait_until(cyc + 6);
        idle_off();

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard left %0d items", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule